// File: doc/BRIEF.md
# Multicycle Load-Store Processor Datapath

This block is the 32-bit datapath of a small multicycle processor that runs eight operations: register add, subtract, AND and OR, word load, word store, branch-if-equal and an absolute jump. One ALU does every calculation, and one memory port serves both instruction fetch and data access. Holding registers carry values from one step to the next: the program counter, the instruction register, the memory data register, the two operand registers and the ALU output register.

The block makes no sequencing decisions. An external sequencer drives one plain control pin or select per datapath action in every cycle. The block returns the opcode field of the held instruction and the ALU zero flag, which the sequencer uses to pick its next step. The memory port is a plain combinational-read, clocked-write port with no handshake. The datapath assumes that a read completes in the same cycle and that a write takes effect at the clock edge where `mem_we` is high. It therefore applies no back-pressure.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_n` is low, the program counter is cleared to `RESET_PC` (default 0) and every register is cleared. After reset, with `addr_from_alu` = 0, `mem_addr` shows 0 and `mem_we` is low.
- R2: On a cycle with `ir_we` = 1, the instruction register captures `mem_rdata`. `opcode` then shows bits [31:26] of that word. With `pc_we` = 1, `pc_next_sel` = 00, `opa_from_reg` = 0, `opb_sel` = 01 and `alu_mode` = 00, the program counter advances by 4.
- R3: With `alu_mode` = 10, the ALU operation is taken from the function field [5:0]: 0x20 adds, 0x22 subtracts, 0x24 is bitwise AND and 0x25 is bitwise OR. `rf_we` with `wr_dst_rd` = 1 and `wb_from_mem` = 0 writes the ALU output register into register [15:11].
- R4: Register 0 always reads as zero. A write to it has no effect.
- R5: The operand A register is loaded from register [25:21] and the operand B register from register [20:16]. With `opa_from_reg` = 1 and `opb_sel` = 10, the ALU output register receives A plus the sign-extended field [15:0]. With `addr_from_alu` = 1, `mem_addr` shows the ALU output register. `mem_wdata` always carries B, and `mem_we` follows `store_en`.
- R6: The memory data register captures `mem_rdata` on every clock edge. `rf_we` with `wr_dst_rd` = 0 and `wb_from_mem` = 1 writes it into register [20:16].
- R7: `alu_mode` = 01 subtracts whatever the function field holds, and `alu_zero` is high exactly when the ALU result is zero. With `opb_sel` = 11 and `opa_from_reg` = 0, the ALU output register receives PC plus the sign-extended field [15:0] shifted left by 2. `pc_we_cond` with `pc_next_sel` = 01 loads the PC from that register only when `alu_zero` is high.
- R8: `pc_we` with `pc_next_sel` = 10 loads the PC with PC[31:28] followed by instruction bits [25:0] and two zero bits.
- R9: When `pc_we` is low and `pc_we_cond` is either low or not met, the program counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_we | input | 1 | Unconditional program counter load |
| pc_we_cond | input | 1 | Program counter load qualified by the zero flag |
| ir_we | input | 1 | Instruction register load |
| rf_we | input | 1 | Register file write |
| addr_from_alu | input | 1 | Memory address select: 0 = PC, 1 = ALU output register |
| wr_dst_rd | input | 1 | Write register select: 0 = bits [20:16], 1 = bits [15:11] |
| wb_from_mem | input | 1 | Write data select: 0 = ALU output register, 1 = memory data register |
| opa_from_reg | input | 1 | ALU first operand: 0 = PC, 1 = A |
| opb_sel | input | 2 | ALU second operand: 00 = B, 01 = 4, 10 = immediate, 11 = immediate shifted left by 2 |
| alu_mode | input | 2 | 00 = add, 01 = subtract, 10 = from function field |
| pc_next_sel | input | 2 | PC source: 00 = ALU result, 01 = ALU output register, 10 = jump address |
| store_en | input | 1 | Memory write request |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| opcode | output | 6 | Opcode field of the held instruction |
| alu_zero | output | 1 | ALU result is zero |

## Verification
Directed programs run first. Base-plus-offset loads and stores with positive and negative offsets show that the sign extension and the address path are correct. A taken and a not-taken branch tell the conditional PC load apart from the hold. A jump checks that the target concatenation is right. Writes to register 0 followed by a store of it expose any path that writes around the zero register. A constrained-random stream then mixes the four register operations, loads from preloaded data, stores, branches and jumps. Dumping every register through stores tells a wrong function-field decode or write destination apart from a correct one. Checking the fetch address after every branch and jump confirms the program-counter sequence.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  typedef enum logic [2:0] {
    FN_AND = 3'b000,
    FN_OR  = 3'b001,
    FN_ADD = 3'b010,
    FN_SUB = 3'b110
  } alu_fn_e;

  typedef enum logic [1:0] {
    OPB_REG  = 2'b00,
    OPB_FOUR = 2'b01,
    OPB_IMM  = 2'b10,
    OPB_BOFF = 2'b11
  } opb_sel_e;

  typedef enum logic [1:0] {
    PCN_ALU  = 2'b00,
    PCN_HELD = 2'b01,
    PCN_JUMP = 2'b10
  } pcn_sel_e;

  typedef enum logic [1:0] {
    MODE_ADD  = 2'b00,
    MODE_SUB  = 2'b01,
    MODE_FUNC = 2'b10
  } alu_mode_e;
endpackage

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] word [DEPTH];

  assign word[0] = '0;

  for (genvar i = 1; i < DEPTH; i++) begin : g_reg
    logic q_we;
    logic [W-1:0] q;
    assign q_we = we && (wa == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (q_we) q <= wd;
    end
    assign word[i] = q;
  end

  assign rd1 = word[ra1];
  assign rd2 = word[ra2];
endmodule

// File: rtl/mcd_alu_ctrl.sv
module mcd_alu_ctrl
  import mcd_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [5:0] funct,
  output alu_fn_e    fn
);
  always_comb begin
    fn = FN_ADD;
    unique case (mode)
      MODE_SUB:  fn = FN_SUB;
      MODE_FUNC: begin
        case (funct)
          6'h22:   fn = FN_SUB;
          6'h24:   fn = FN_AND;
          6'h25:   fn = FN_OR;
          default: fn = FN_ADD;
        endcase
      end
      default:   fn = FN_ADD;
    endcase
  end
endmodule

// File: rtl/mcd_alu.sv
module mcd_alu
  import mcd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (fn)
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_SUB:  y = a - b;
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mcd_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pc_we,
  input  logic        pc_we_cond,
  input  logic        ir_we,
  input  logic        rf_we,
  input  logic        addr_from_alu,
  input  logic        wr_dst_rd,
  input  logic        wb_from_mem,
  input  logic        opa_from_reg,
  input  logic [1:0]  opb_sel,
  input  logic [1:0]  alu_mode,
  input  logic [1:0]  pc_next_sel,
  input  logic        store_en,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_we,
  output logic [5:0]  opcode,
  output logic        alu_zero
);
  localparam int IMM_W = 16;

  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
  logic [XLEN-1:0] rs_data, rt_data, wr_data;
  logic [XLEN-1:0] imm_ext, imm_boff, jump_tgt;
  logic [XLEN-1:0] opnd_a, opnd_b, alu_y, pc_next;
  logic [REG_AW-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
  logic            pc_load;
  alu_fn_e         alu_fn;

  // instruction fields
  assign rs_idx   = ir_q[25:21];
  assign rt_idx   = ir_q[20:16];
  assign rd_idx   = ir_q[15:11];
  assign imm_ext  = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_boff = {imm_ext[XLEN-3:0], 2'b00};
  assign jump_tgt = {pc_q[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};
  assign opcode   = ir_q[31:26];

  mcd_regfile #(.W(XLEN), .AW(REG_AW)) i_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .ra1  (rs_idx),
    .ra2  (rt_idx),
    .rd1  (rs_data),
    .rd2  (rt_data),
    .we   (rf_we),
    .wa   (wr_idx),
    .wd   (wr_data)
  );

  assign wr_idx  = wr_dst_rd   ? rd_idx : rt_idx;
  assign wr_data = wb_from_mem ? mdr_q  : aluout_q;

  // operand selection
  assign opnd_a = opa_from_reg ? a_q : pc_q;
  always_comb begin
    unique case (opb_sel_e'(opb_sel))
      OPB_REG:  opnd_b = b_q;
      OPB_FOUR: opnd_b = XLEN'(4);
      OPB_IMM:  opnd_b = imm_ext;
      default:  opnd_b = imm_boff;
    endcase
  end

  mcd_alu_ctrl i_actl (
    .mode (alu_mode),
    .funct(ir_q[5:0]),
    .fn   (alu_fn)
  );

  mcd_alu #(.W(XLEN)) i_alu (
    .a   (opnd_a),
    .b   (opnd_b),
    .fn  (alu_fn),
    .y   (alu_y),
    .zero(alu_zero)
  );

  // program counter source
  always_comb begin
    unique case (pcn_sel_e'(pc_next_sel))
      PCN_HELD: pc_next = aluout_q;
      PCN_JUMP: pc_next = jump_tgt;
      default:  pc_next = alu_y;
    endcase
  end
  assign pc_load = pc_we || (pc_we_cond && alu_zero);

  // holding registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= RESET_PC;
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      if (pc_load) pc_q <= pc_next;
      if (ir_we)   ir_q <= mem_rdata;
      mdr_q    <= mem_rdata;
      a_q      <= rs_data;
      b_q      <= rt_data;
      aluout_q <= alu_y;
    end
  end

  // memory port
  assign mem_addr  = addr_from_alu ? aluout_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_we    = store_en;
endmodule

// File: rtl/mcd_checker.sv
module mcd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        pc_we,
  input logic        pc_we_cond,
  input logic        ir_we,
  input logic        opa_from_reg,
  input logic [1:0]  opb_sel,
  input logic [1:0]  alu_mode,
  input logic [1:0]  pc_next_sel,
  input logic        alu_zero,
  input logic [31:0] mem_rdata,
  input logic [31:0] pc_q,
  input logic [31:0] ir_q,
  input logic [31:0] rs_data
);
  AST_IR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ir_we |=> ir_q == $past(mem_rdata)); // R2

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_we |=> $stable(ir_q)); // R2

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && pc_next_sel == 2'b00 && !opa_from_reg && opb_sel == 2'b01 && alu_mode == 2'b00)
    |=> pc_q == $past(pc_q) + 32'd4); // R2

  AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    ir_q[25:21] == 5'd0 |-> rs_data == 32'd0); // R4

  AST_BRANCH_UNTAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we_cond && !pc_we && !alu_zero) |=> $stable(pc_q)); // R7

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && pc_next_sel == 2'b10)
    |=> pc_q == {$past(pc_q[31:28]), $past(ir_q[25:0]), 2'b00}); // R8

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_we && !pc_we_cond) |=> $stable(pc_q)); // R9
endmodule

bind mc_datapath mcd_checker i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pc_we       (pc_we),
  .pc_we_cond  (pc_we_cond),
  .ir_we       (ir_we),
  .opa_from_reg(opa_from_reg),
  .opb_sel     (opb_sel),
  .alu_mode    (alu_mode),
  .pc_next_sel (pc_next_sel),
  .alu_zero    (alu_zero),
  .mem_rdata   (mem_rdata),
  .pc_q        (pc_q),
  .ir_q        (ir_q),
  .rs_data     (rs_data)
);

// File: tb/test_mc_datapath.sv
`timescale 1ns/1ps
module test_mc_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pc_we, pc_we_cond, ir_we, rf_we, addr_from_alu;
  logic        wr_dst_rd, wb_from_mem, opa_from_reg, store_en;
  logic [1:0]  opb_sel, alu_mode, pc_next_sel;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic        mem_we, alu_zero;
  logic [5:0]  opcode;

  logic [31:0] mem [1024];
  logic [31:0] gold [32];
  logic [31:0] gpc;
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 1'b0;

  always #5 clk = ~clk;

  mc_datapath i_mc_datapath (
    .clk(clk), .rst_n(rst_n), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
    .ir_we(ir_we), .rf_we(rf_we), .addr_from_alu(addr_from_alu),
    .wr_dst_rd(wr_dst_rd), .wb_from_mem(wb_from_mem),
    .opa_from_reg(opa_from_reg), .opb_sel(opb_sel), .alu_mode(alu_mode),
    .pc_next_sel(pc_next_sel), .store_en(store_en), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .opcode(opcode), .alu_zero(alu_zero)
  );

  assign mem_rdata = mem[mem_addr[11:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] ref_op(input logic [5:0] f, input logic [31:0] a,
                                         input logic [31:0] b);
    case (f)
      6'h22:   return a - b;
      6'h24:   return a & b;
      6'h25:   return a | b;
      default: return a + b;
    endcase
  endfunction

  task automatic idle();
    pc_we = 0; pc_we_cond = 0; ir_we = 0; rf_we = 0; addr_from_alu = 0;
    wr_dst_rd = 0; wb_from_mem = 0; opa_from_reg = 0; store_en = 0;
    opb_sel = 2'b00; alu_mode = 2'b00; pc_next_sel = 2'b00;
  endtask

  task automatic step();
    @(posedge clk); #1;
    idle();
    #1;
  endtask

  // fetch and decode; checks fetch address, opcode and PC advance
  task automatic fetch(input logic [31:0] instr);
    mem[gpc[11:2]] = instr;
    check(mem_addr == gpc, "R9 fetch address", mem_addr, gpc);
    ir_we = 1; pc_we = 1; opb_sel = 2'b01;
    step();
    check(opcode == instr[31:26], "R2 opcode", {26'd0, opcode}, {26'd0, instr[31:26]});
    gpc = gpc + 4;
    check(mem_addr == gpc, "R2 pc advance", mem_addr, gpc);
    opb_sel = 2'b11;
    step();
  endtask

  task automatic rop(input logic [4:0] rd, input logic [4:0] rs, input logic [4:0] rt,
                     input logic [5:0] f);
    fetch({6'd0, rs, rt, rd, 5'd0, f});
    opa_from_reg = 1; alu_mode = 2'b10;
    step();
    rf_we = 1; wr_dst_rd = 1;
    step();
    if (rd != 0) gold[rd] = ref_op(f, gold[rs], gold[rt]); // R3, R4
  endtask

  task automatic st(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] off,
                    input string req);
    logic [31:0] ea;
    fetch({6'h2B, rs, rt, off});
    ea = gold[rs] + sx(off);
    opa_from_reg = 1; opb_sel = 2'b10;
    step();
    addr_from_alu = 1; store_en = 1;
    #1;
    check(mem_addr == ea, "R5 store address", mem_addr, ea);
    check(mem_we == 1'b1, "R5 store enable", {31'd0, mem_we}, 32'd1);
    check(mem_wdata == gold[rt], req, mem_wdata, gold[rt]);
    step();
  endtask

  task automatic ld(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] off);
    logic [31:0] ea;
    logic [31:0] val;
    fetch({6'h23, rs, rt, off});
    ea = gold[rs] + sx(off);
    opa_from_reg = 1; opb_sel = 2'b10;
    step();
    addr_from_alu = 1;
    #1;
    check(mem_addr == ea, "R5 load address", mem_addr, ea);
    val = mem[ea[11:2]];
    step();
    rf_we = 1; wb_from_mem = 1;
    step();
    if (rt != 0) gold[rt] = val; // R6
  endtask

  task automatic beq(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] off);
    logic taken;
    logic [31:0] tgt;
    fetch({6'h04, rs, rt, off});
    tgt = gpc + {sx(off)[29:0], 2'b00};
    taken = (gold[rs] == gold[rt]);
    opa_from_reg = 1; alu_mode = 2'b01; pc_we_cond = 1; pc_next_sel = 2'b01;
    #1;
    check(alu_zero == taken, "R7 zero flag", {31'd0, alu_zero}, {31'd0, taken});
    step();
    if (taken) gpc = tgt;
    check(mem_addr == gpc, "R7 branch result", mem_addr, gpc);
  endtask

  task automatic jmp(input logic [25:0] t);
    fetch({6'h02, t});
    pc_we = 1; pc_next_sel = 2'b10;
    step();
    gpc = {gpc[31:28], t, 2'b00};
    check(mem_addr == gpc, "R8 jump target", mem_addr, gpc);
  endtask

  task automatic dump_regs();
    for (int r = 0; r < 32; r++) st(5'(r), 5'd0, 16'h0E00 + 16'(4 * r), "R3 register dump");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int i = 768; i < 896; i++) mem[i] = $urandom;
    mem[768] = 32'h0000_0C40;          // base pointer at 0xC00
    mem[783] = 32'h8000_0001;          // word at 0xC3C
    for (int i = 0; i < 32; i++) gold[i] = '0;
    gpc = 32'h0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    #1;
    // R1 reset state
    check(mem_addr == 32'h0, "R1 reset pc", mem_addr, 32'h0);
    check(mem_we == 1'b0, "R1 reset write enable", {31'd0, mem_we}, 32'd0);
    @(negedge clk);

    // directed: loads with positive and negative offsets (R5, R6)
    ld(5'd9, 5'd0, 16'h0C00);
    ld(5'd3, 5'd9, 16'hFFFC);
    st(5'd3, 5'd9, 16'hFFF8, "R6 loaded value");
    st(5'd9, 5'd0, 16'h0C80, "R6 base value");
    // R3 each function
    rop(5'd4, 5'd9, 5'd3, 6'h20);
    rop(5'd5, 5'd9, 5'd3, 6'h22);
    rop(5'd6, 5'd9, 5'd3, 6'h24);
    rop(5'd7, 5'd9, 5'd3, 6'h25);
    st(5'd4, 5'd0, 16'h0C84, "R3 add");
    st(5'd5, 5'd0, 16'h0C88, "R3 sub");
    st(5'd6, 5'd0, 16'h0C8C, "R3 and");
    st(5'd7, 5'd0, 16'h0C90, "R3 or");
    // R4 writes to register 0 are ignored
    rop(5'd0, 5'd9, 5'd3, 6'h25);
    ld(5'd0, 5'd9, 16'hFFFC);
    st(5'd0, 5'd0, 16'h0C94, "R4 zero register");
    // R7 taken and not taken, R8 jump
    beq(5'd9, 5'd9, 16'd2);
    beq(5'd0, 5'd9, 16'd1);
    jmp(26'h000_0020);

    // constrained random program
    for (int n = 0; n < 400; n++) begin
      int kind;
      kind = $urandom % 10;
      if (gpc > 32'h0A00) kind = 9;
      case (kind)
        6:       beq(5'($urandom), 5'($urandom % 4), 16'($urandom % 4));
        7:       st(5'($urandom), 5'd0, 16'h0C00 + 16'(4 * ($urandom % 128)), "R5 random store");
        8:       ld(5'($urandom), 5'd0, 16'h0C00 + 16'(4 * ($urandom % 128)));
        9:       jmp(26'h000_0010 + 26'($urandom % 16));
        default: begin
          logic [5:0] f;
          case ($urandom % 4)
            0: f = 6'h20;
            1: f = 6'h22;
            2: f = 6'h24;
            default: f = 6'h25;
          endcase
          rop(5'($urandom), 5'($urandom), 5'($urandom), f);
        end
      endcase
      if (n % 100 == 99) dump_regs();
    end
    dump_regs();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule